// File: doc/BRIEF.md
# Clock-Selectable Serial Shift Unit

This block pairs an eight-bit shift register with a four-bit transfer counter. Both advance on one shared shift clock. That clock comes from one of three places: an external serial clock pin, a periodic tick from a timer, or a strobe raised by software. Software reads and writes the register and the counter over a simple parallel bus. It starts a transfer by loading the outgoing byte and presetting the counter. It then waits for the overflow flag, and reads the received byte from the same register. The register has no receive buffer.

Incoming bits always enter at the register's LSB from one data-input pin, whatever the wire mode. The register's MSB reaches the outside world through an output latch. A mode input decides whether that latch drives the three-wire data-out pin or the two-wire data pin. When the external clock is selected, the counter advances on both clock edges, so a full byte takes sixteen counts. The output latch stays closed while the clock is high, so a new MSB appears only after the falling edge, which is the edge opposite the sampling edge. The external clock and the data input each pass through a two-flop synchronizer before use.

Top module: `serial_shift_unit`

## Requirements
- R1: After a synchronous reset, the register reads 0x00, the counter reads 0, the overflow flag and the interrupt are 0, the three-wire output is 0 and the two-wire output is 1.
- R2: A bus data write loads the register on the next edge, and a bus counter write presets the counter from bus bits [3:0]. Either write takes priority over a shift or count event in the same cycle, and a counter write never sets the overflow flag.
- R3: With source code 1 (software), each strobe cycle shifts the register left by one and increments the counter once. Source code 2 (timer tick) behaves the same way with tick pulses. A pulse on the source that is not selected changes nothing.
- R4: With source code 3 (external), a rising edge of the synchronized clock shifts the register. Both rising and falling edges increment the counter, so eight clock periods from a preset of 0 wrap the counter to 0.
- R5: A count event at counter value 15 wraps it to 0 and sets the overflow flag. The flag stays set until a clear strobe. A set and a clear in the same cycle leave the flag set.
- R6: The interrupt output is high exactly when the overflow flag and the interrupt enable are both high.
- R7: With the external source, the output latch holds its value while the synchronized clock is high, and takes the new MSB once the clock is low. With the other sources, the latch follows the MSB one cycle after it changes.
- R8: With the wire-mode input at 0, the three-wire output carries the latch and the two-wire output is held at 1. With the wire-mode input at 1, the two outputs swap these roles.
- R9: With source code 0 (off), strobes, ticks and external clock edges change neither the register nor the counter.
- R10: The shifted-in bit is always the synchronized value of the data-input pin, in either wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | 2 | Shift clock source: 0 off, 1 software, 2 timer tick, 3 external |
| cfg_two_wire | input | 1 | Wire mode: 0 drives the three-wire output, 1 drives the two-wire output |
| ext_sclk | input | 1 | External serial clock pin (asynchronous) |
| ser_in | input | 1 | Serial data input pin (asynchronous) |
| tick_in | input | 1 | Single-cycle timer overflow tick |
| sw_strobe | input | 1 | Single-cycle software clock strobe |
| bus_we_data | input | 1 | Write strobe for the shift register |
| bus_we_cnt | input | 1 | Write strobe for the counter |
| bus_wdata | input | 8 | Bus write data |
| bus_clr_ovf | input | 1 | Clears the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| data_q | output | 8 | Shift register contents |
| cnt_q | output | 4 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| out_3w | output | 1 | Three-wire data-out pin |
| out_2w | output | 1 | Two-wire data pin drive level |

## Verification
Two pairs of functions can fall in one cycle. The first is a counter wrap that sets the overflow flag while software clears it. The second is a bus write to the register or the counter while a shift strobe arrives. The bench provokes both by raising the strobe on the same edge as the clear or the write, with the counter preset to 15 or to another value. For the flag, the rule is that the set wins. For the counter and the register, the bus write wins, and a counter write at 15 produces no overflow. The bench also sweeps every register and counter value through the bus, and shifts known bytes under each clock source to compare against arithmetic expectations.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SW   = 2'd1,
    SRC_TICK = 2'd2,
    SRC_EXT  = 2'd3
  } clk_src_e;
endpackage

// File: rtl/ssu_sync.sv
module ssu_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= '0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ssu_clk_sel.sv
module ssu_clk_sel
  import ssu_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  clk_src_e src,
  input  logic     sclk_lvl,
  input  logic     sw_strobe,
  input  logic     tick_in,
  output logic     shift_ev,
  output logic     count_ev,
  output logic     hold_out
);
  logic sclk_prev;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_lvl;
  end

  assign rise = sclk_lvl & ~sclk_prev;
  assign fall = ~sclk_lvl & sclk_prev;

  always_comb begin
    shift_ev = 1'b0;
    count_ev = 1'b0;
    case (src)
      SRC_SW:   begin shift_ev = sw_strobe; count_ev = sw_strobe;   end
      SRC_TICK: begin shift_ev = tick_in;   count_ev = tick_in;     end
      SRC_EXT:  begin shift_ev = rise;      count_ev = rise | fall; end
      default:  begin shift_ev = 1'b0;      count_ev = 1'b0;        end
    endcase
  end

  assign hold_out = (src == SRC_EXT) & sclk_lvl;

  // R9: with the source off, no event may leave this selector
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_OFF) |-> !(shift_ev || count_ev));
endmodule

// File: rtl/ssu_shifter.sv
module ssu_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              ser_bit,
  input  logic              hold,
  output logic [DATA_W-1:0] data_q,
  output logic              msb_lat
);
  logic [DATA_W-1:0] data_r;
  logic              lat_r;

  always_ff @(posedge clk) begin
    if (rst)        data_r <= '0;
    else if (load)  data_r <= load_val;
    else if (shift) data_r <= {data_r[DATA_W-2:0], ser_bit};
  end

  always_ff @(posedge clk) begin
    if (rst)        lat_r <= 1'b0;
    else if (!hold) lat_r <= data_r[DATA_W-1];
  end

  assign data_q  = data_r;
  assign msb_lat = lat_r;

  // R7: latch closed while the external clock is high
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    hold |=> (msb_lat == $past(msb_lat)));

  // R2: a bus write wins over a shift in the same cycle
  p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (data_q == $past(load_val)));
endmodule

// File: rtl/ssu_counter.sv
module ssu_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_r;
  logic             ovf_r;
  logic             wrap;

  assign wrap = inc & !load & (cnt_r == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)       cnt_r <= '0;
    else if (load) cnt_r <= load_val;
    else if (inc)  cnt_r <= cnt_r + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       ovf_r <= 1'b0;
    else if (wrap) ovf_r <= 1'b1;
    else if (clr)  ovf_r <= 1'b0;
  end

  assign cnt_q = cnt_r;
  assign ovf_q = ovf_r;

  // R5: a wrap always raises the flag, even against a clear
  p_wrap_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && cnt_q == CNT_MAX) |=> (ovf_q && cnt_q == '0));

  // R5: flag is sticky until cleared
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr) |=> ovf_q);

  // R2: counter preset from the bus
  p_preset_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit
  import ssu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_src,
  input  logic              cfg_two_wire,
  input  logic              ext_sclk,
  input  logic              ser_in,
  input  logic              tick_in,
  input  logic              sw_strobe,
  input  logic              bus_we_data,
  input  logic              bus_we_cnt,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_clr_ovf,
  input  logic              ovf_ie,
  output logic [DATA_W-1:0] data_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ovf_flag,
  output logic              irq,
  output logic              out_3w,
  output logic              out_2w
);
  localparam int SYNC_W = 2;

  clk_src_e          src;
  logic [SYNC_W-1:0] pins_sync;
  logic              sclk_lvl, din_lvl;
  logic              shift_ev, count_ev, hold_out;
  logic              msb_lat;

  assign src = clk_src_e'(cfg_src);

  ssu_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({ext_sclk, ser_in}),
    .sync_out (pins_sync)
  );

  assign sclk_lvl = pins_sync[1];
  assign din_lvl  = pins_sync[0];

  ssu_clk_sel u_sel (
    .clk       (clk),
    .rst       (rst),
    .src       (src),
    .sclk_lvl  (sclk_lvl),
    .sw_strobe (sw_strobe),
    .tick_in   (tick_in),
    .shift_ev  (shift_ev),
    .count_ev  (count_ev),
    .hold_out  (hold_out)
  );

  ssu_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (bus_we_data),
    .load_val (bus_wdata),
    .shift    (shift_ev),
    .ser_bit  (din_lvl),
    .hold     (hold_out),
    .data_q   (data_q),
    .msb_lat  (msb_lat)
  );

  ssu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (bus_we_cnt),
    .load_val (bus_wdata[CNT_W-1:0]),
    .inc      (count_ev),
    .clr      (bus_clr_ovf),
    .cnt_q    (cnt_q),
    .ovf_q    (ovf_flag)
  );

  assign irq    = ovf_flag & ovf_ie;
  assign out_3w = cfg_two_wire ? 1'b1 : msb_lat;
  assign out_2w = cfg_two_wire ? msb_lat : 1'b1;

  // R9: register untouched while the source is off
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_src == 2'd0 && !bus_we_data) |=> (data_q == $past(data_q)));
endmodule

// File: tb/serial_shift_unit_tb.sv
module serial_shift_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cfg_src;
  logic       cfg_two_wire, ext_sclk, ser_in, tick_in, sw_strobe;
  logic       bus_we_data, bus_we_cnt, bus_clr_ovf, ovf_ie;
  logic [7:0] bus_wdata;
  logic [7:0] data_q;
  logic [3:0] cnt_q;
  logic       ovf_flag, irq, out_3w, out_2w;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  serial_shift_unit u_dut (
    .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_two_wire(cfg_two_wire),
    .ext_sclk(ext_sclk), .ser_in(ser_in), .tick_in(tick_in), .sw_strobe(sw_strobe),
    .bus_we_data(bus_we_data), .bus_we_cnt(bus_we_cnt), .bus_wdata(bus_wdata),
    .bus_clr_ovf(bus_clr_ovf), .ovf_ie(ovf_ie), .data_q(data_q), .cnt_q(cnt_q),
    .ovf_flag(ovf_flag), .irq(irq), .out_3w(out_3w), .out_2w(out_2w)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_data(logic [7:0] v);
    @(negedge clk); bus_we_data = 1'b1; bus_wdata = v;
    @(negedge clk); bus_we_data = 1'b0;
  endtask

  task automatic write_cnt(logic [3:0] v);
    @(negedge clk); bus_we_cnt = 1'b1; bus_wdata = {4'h0, v};
    @(negedge clk); bus_we_cnt = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); bus_clr_ovf = 1'b1;
    @(negedge clk); bus_clr_ovf = 1'b0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_strobe = 1'b1;
    @(negedge clk); sw_strobe = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk); tick_in = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] exp;
    logic       b;
    rst = 1'b1; cfg_src = 2'd0; cfg_two_wire = 1'b0; ext_sclk = 1'b0;
    ser_in = 1'b0; tick_in = 1'b0; sw_strobe = 1'b0; bus_we_data = 1'b0;
    bus_we_cnt = 1'b0; bus_clr_ovf = 1'b0; ovf_ie = 1'b0; bus_wdata = '0;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);

    // R1 reset state
    check("R1 data", data_q, 0);
    check("R1 cnt", cnt_q, 0);
    check("R1 flag", ovf_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 out_3w", out_3w, 0);
    check("R1 out_2w", out_2w, 1);

    // R2 exhaustive bus sweeps
    for (int v = 0; v < 256; v++) begin
      write_data(8'(v));
      check("R2 data write", data_q, v);
    end
    for (int v = 0; v < 16; v++) begin
      write_cnt(4'(v));
      check("R2 cnt preset", cnt_q, v);
    end

    // R9 source off: nothing moves
    write_data(8'h5A); write_cnt(4'd3);
    pulse_sw(); pulse_tick();
    ext_sclk = 1'b1; wait_n(4); ext_sclk = 1'b0; wait_n(4);
    check("R9 data", data_q, 8'h5A);
    check("R9 cnt", cnt_q, 3);

    // R3 software strobe, preset 8 so the 8th bit overflows (R5)
    cfg_src = 2'd1;
    write_data(8'hA5); write_cnt(4'd8); clear_flag();
    exp = 8'hA5;
    for (int i = 7; i >= 0; i--) begin
      b = (8'h3C >> i) & 1'b1;
      ser_in = b; wait_n(2);
      pulse_sw();
      exp = {exp[6:0], b};
      check("R3 sw shift", data_q, exp);
      check("R3 sw count", cnt_q, (8 + (8 - i)) % 16);
    end
    check("R5 wrap flag", ovf_flag, 1);
    wait_n(1);
    check("R7 internal follow", out_3w, exp[7]);
    pulse_tick();
    check("R3 tick ignored in sw", data_q, 8'h3C);
    check("R6 irq disabled", irq, 0);
    ovf_ie = 1'b1; wait_n(1);
    check("R6 irq enabled", irq, 1);
    wait_n(5);
    check("R5 sticky", ovf_flag, 1);
    clear_flag();
    check("R5 cleared", ovf_flag, 0);
    check("R6 irq after clear", irq, 0);

    // R5 set and clear collide: set wins
    write_cnt(4'd15);
    @(negedge clk); sw_strobe = 1'b1; bus_clr_ovf = 1'b1;
    @(negedge clk); sw_strobe = 1'b0; bus_clr_ovf = 1'b0;
    check("R5 set beats clear", ovf_flag, 1);
    check("R5 wrap to 0", cnt_q, 0);
    clear_flag();

    // R2 bus writes beat events
    write_cnt(4'd5);
    @(negedge clk); bus_we_cnt = 1'b1; bus_wdata = 8'h0B; sw_strobe = 1'b1;
    @(negedge clk); bus_we_cnt = 1'b0; sw_strobe = 1'b0;
    check("R2 cnt write beats count", cnt_q, 11);
    write_cnt(4'd15);
    @(negedge clk); bus_we_cnt = 1'b1; bus_wdata = 8'h0F; sw_strobe = 1'b1;
    @(negedge clk); bus_we_cnt = 1'b0; sw_strobe = 1'b0;
    check("R2 no ovf on write", ovf_flag, 0);
    @(negedge clk); bus_we_data = 1'b1; bus_wdata = 8'hC3; sw_strobe = 1'b1;
    @(negedge clk); bus_we_data = 1'b0; sw_strobe = 1'b0;
    check("R2 data write beats shift", data_q, 8'hC3);

    // R3 timer tick source
    cfg_src = 2'd2;
    write_data(8'h00); write_cnt(4'd0);
    ser_in = 1'b1; wait_n(2);
    pulse_tick(); pulse_tick(); pulse_tick();
    check("R3 tick shift", data_q, 8'h07);
    check("R3 tick count", cnt_q, 3);
    pulse_sw();
    check("R3 sw ignored in tick", data_q, 8'h07);

    // R4 external clock, both edges counted
    cfg_src = 2'd3; ext_sclk = 1'b0; wait_n(4);
    write_data(8'h00); write_cnt(4'd0); clear_flag();
    for (int i = 7; i >= 0; i--) begin
      ser_in = (8'h96 >> i) & 1'b1;
      wait_n(4);
      ext_sclk = 1'b1; wait_n(4);
      check("R4 edge count", cnt_q, (2 * (7 - i) + 1) % 16);
      ext_sclk = 1'b0;
    end
    wait_n(5);
    check("R4 ext byte", data_q, 8'h96);
    check("R4 ext wrap", cnt_q, 0);
    check("R4 ext flag", ovf_flag, 1);
    clear_flag();

    // R7 latch held while clock high
    write_data(8'h80); ser_in = 1'b0; wait_n(3);
    check("R7 latch open low", out_3w, 1);
    ext_sclk = 1'b1; wait_n(4);
    check("R7 shifted", data_q, 8'h00);
    check("R7 latch holds high", out_3w, 1);
    ext_sclk = 1'b0; wait_n(4);
    check("R7 latch after fall", out_3w, 0);

    // R8 / R10 two-wire mode
    cfg_src = 2'd1; cfg_two_wire = 1'b1;
    write_data(8'h80); wait_n(2);
    check("R8 2w carries 1", out_2w, 1);
    write_data(8'h00); wait_n(2);
    check("R8 2w carries 0", out_2w, 0);
    check("R8 3w parked", out_3w, 1);
    ser_in = 1'b1; wait_n(2);
    pulse_sw();
    check("R10 input in 2w mode", data_q, 8'h01);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule